// File: doc/BRIEF.md
# I2C Byte-at-a-Time Master

This block is the master side of an I2C port. Firmware drives it one byte at a time through two registers. The control/status register starts, continues, restarts and ends a transfer. The data register has a write half that holds the next byte to send and a read half that returns the last byte received.

To begin a transfer, firmware loads the target address into the data register. It then writes master, continue and transmit in one control write. The engine generates a start condition, shifts the byte out MSB first and samples the target's acknowledge. It then holds SCL low and raises an interrupt.

Each later byte (transmit or receive), a repeated start, or a stop condition is requested by one more control write that carries the continue bit. A busy interlock rejects control writes while a byte is in flight. Arbitration loss is reported through a status bit. Clock stretching by other devices is honoured.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control/status read is 0x00, the data read is 0x00, the interrupt is low and neither SCL nor SDA is pulled low.
- R2: A control write with bit 7 (master) and bit 6 (continue) set while the bus is idle makes SDA fall while SCL is high. The engine then sends the data-register byte MSB first, as the address.
- R3: Bit 6 reads 1 (busy) from the edge after a control write that sets continue. While it reads 1, control writes are ignored: enable (bit 0) and transmit (bit 5) keep their values.
- R4: When a byte, a stop or an arbitration loss completes, the interrupt rises with busy already clear. The next accepted control write clears the interrupt.
- R5: In transmit mode (bit 5 = 1), bit 4 is set to 1 when the target pulls SDA low on the ninth clock, and to 0 when SDA is left high.
- R6: In receive mode (bit 5 = 0), the data read returns the byte the target shifted out. On the ninth clock the master pulls SDA low only when bit 4 is 1.
- R7: If a transmitted 1 is sampled low while SCL is high, the engine clears bit 7, sets bit 2, raises the interrupt and releases both lines.
- R8: From the held state, a control write with master, continue and bit 2 (restart) set produces a new start with no stop in between and sends the data-register byte. Bit 2 reads 0 once the byte is done.
- R9: From the held state, a control write with continue set and master clear produces a stop (SDA rises while SCL is high), sets bit 1 and raises the interrupt.
- R10: While the engine has released SCL and the line still reads low, the high phase is extended and the engine does not pull SCL low again.
- R11: Bit 0 (enable) flags the two pins of the port chosen by the select input as open-drain: port A when select is 0, port B when select is 1, never both. With bit 0 clear, neither line is ever pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Write strobe for the control register |
| data_we | input | 1 | Write strobe for the transmit data register |
| wdata | input | 8 | Write data for either register |
| ctl_rd | output | 8 | Control/status read value |
| data_rd | output | 8 | Last received byte |
| irq | output | 1 | Interrupt request, level |
| port_sel | input | 1 | Selects port A (0) or port B (1) for the bus pins |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| od_port_a | output | 2 | Open-drain mode for port A pins 1:0 |
| od_port_b | output | 2 | Open-drain mode for port B pins 1:0 |

## Verification
The bench builds the engine with a five-cycle half period. This keeps each byte near a hundred cycles, so whole transfers with start, address, data, restart and stop fit easily in one run. A five-cycle phase is still longer than the two-stage input synchronizer, so SDA is sampled well after it settles. It also leaves room for a hundred-cycle SCL hold by the bench's target, long enough to measure the stretched high phase against an unstretched byte.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int HALF_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_rd,
  output logic [7:0] data_rd,
  output logic       irq,
  input  logic       port_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [1:0] od_port_a,
  output logic [1:0] od_port_b
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_LOW, S_HIGH, S_HOLD,
    S_RS_LOW, S_RS_HIGH, S_P_LOW, S_P_HIGH, S_P_END
  } st_t;

  st_t st;
  logic f_mstr, f_busy, f_xmit, f_ack, f_addr, f_arb, f_stop, f_en;
  logic [7:0] tx_reg, rx_reg, shreg;
  logic [3:0] bitcnt;
  logic [CW-1:0] cnt;
  logic [1:0] scl_s, sda_s;
  logic sda_q, sda_next, bitdrv, scl_drv, stretch_st, done;

  assign done       = (cnt == '0);
  assign bitdrv     = (bitcnt != 4'd8) ? (f_xmit & ~shreg[7]) : (~f_xmit & f_ack);
  assign stretch_st = (st == S_HIGH) || (st == S_RS_HIGH) || (st == S_P_HIGH);
  assign scl_drv    = (st == S_LOW) || (st == S_HOLD) || (st == S_RS_LOW) || (st == S_P_LOW);

  always_comb begin
    case (st)
      S_START, S_P_LOW, S_P_HIGH: sda_next = 1'b1;
      S_LOW, S_HIGH:              sda_next = bitdrv;
      default:                    sda_next = 1'b0;
    endcase
  end

  assign scl_oe    = f_en & scl_drv;
  assign sda_oe    = f_en & sda_q;
  assign ctl_rd    = {f_mstr, f_busy, f_xmit, f_ack, f_addr, f_arb, f_stop, f_en};
  assign data_rd   = rx_reg;
  assign od_port_a = {2{f_en & ~port_sel}};
  assign od_port_b = {2{f_en & port_sel}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {f_mstr, f_busy, f_xmit, f_ack, f_addr, f_arb, f_stop, f_en} <= '0;
      tx_reg <= '0;
      rx_reg <= '0;
      shreg  <= '0;
      bitcnt <= '0;
      cnt    <= '0;
      scl_s  <= 2'b11;
      sda_s  <= 2'b11;
      sda_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      sda_q <= sda_next;
      if (data_we) tx_reg <= wdata;
      if (ctl_we && !f_busy) begin
        {f_mstr, f_xmit, f_ack, f_addr, f_arb, f_stop, f_en} <= {wdata[7], wdata[5:0]};
        irq <= 1'b0;
        if (wdata[6]) begin
          if (st == S_IDLE && wdata[7]) begin
            f_busy <= 1'b1;
            f_arb  <= 1'b0;
            shreg  <= tx_reg;
            bitcnt <= '0;
            cnt    <= HALF_M1;
            st     <= S_START;
          end else if (st == S_HOLD) begin
            f_busy <= 1'b1;
            shreg  <= tx_reg;
            bitcnt <= '0;
            cnt    <= HALF_M1;
            if (!wdata[7])     st <= S_P_LOW;
            else if (wdata[2]) st <= S_RS_LOW;
            else               st <= S_LOW;
          end
        end
      end else if (stretch_st && !scl_s[1]) begin
        cnt <= HALF_M1;
      end else if (!done) begin
        cnt <= cnt - CW'(1);
      end else begin
        cnt <= HALF_M1;
        case (st)
          S_START: begin
            f_arb <= 1'b0;
            st    <= S_LOW;
          end
          S_LOW:     st <= S_HIGH;
          S_RS_LOW:  st <= S_RS_HIGH;
          S_RS_HIGH: st <= S_START;
          S_P_LOW:   st <= S_P_HIGH;
          S_P_HIGH:  st <= S_P_END;
          S_P_END: begin
            st     <= S_IDLE;
            f_busy <= 1'b0;
            f_stop <= 1'b1;
            irq    <= 1'b1;
          end
          S_HIGH: begin
            if (bitcnt != 4'd8) begin
              if (f_xmit && shreg[7] && !sda_s[1]) begin
                st     <= S_IDLE;
                f_mstr <= 1'b0;
                f_arb  <= 1'b1;
                f_busy <= 1'b0;
                irq    <= 1'b1;
              end else begin
                shreg  <= {shreg[6:0], sda_s[1]};
                bitcnt <= bitcnt + 4'd1;
                st     <= S_LOW;
              end
            end else begin
              if (f_xmit) f_ack <= ~sda_s[1];
              else        rx_reg <= shreg;
              st     <= S_HOLD;
              f_busy <= 1'b0;
              irq    <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_rd,
  input logic       irq,
  input logic       scl_in,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [1:0] od_port_a,
  input logic [1:0] od_port_b
);
  // R3
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[6] && ctl_we) |=> (ctl_rd[0] == $past(ctl_rd[0]) && ctl_rd[5] == $past(ctl_rd[5])));

  // R4
  irq_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !ctl_rd[6]);

  // R4
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ctl_we && !ctl_rd[6]) |=> !irq);

  // R7
  arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_rd[2]) && !$past(ctl_we)) |-> (!ctl_rd[7] && irq));

  // R10
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[0] && ctl_rd[6] && !scl_oe && !scl_in) |=> !scl_oe);

  // R11
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rd[0] |-> (!scl_oe && !sda_oe));

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|od_port_a) && (|od_port_b)));
endmodule

bind i2c_byte_master i2c_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rd(ctl_rd), .irq(irq),
  .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .od_port_a(od_port_a), .od_port_b(od_port_b)
);

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, data_we = 1'b0, port_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctl_rd, data_rd;
  logic irq, scl_oe, sda_oe;
  logic [1:0] od_port_a, od_port_b;
  logic stretch = 1'b0, force_low = 1'b0, ack_en = 1'b0, slv_tx = 1'b0, slv_drv;
  logic [7:0] sbyte = '0, srx = '0;
  logic mack = 1'b0;
  int pcount = 0, lowpos = 0, starts = 0, stops = 0;
  int checks = 0, fails = 0, cyc = 0;
  wire scl_bus = !(scl_oe | stretch);
  wire sda_bus = !(sda_oe | slv_drv | force_low);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  i2c_byte_master #(.HALF_CYC(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .data_we(data_we), .wdata(wdata),
    .ctl_rd(ctl_rd), .data_rd(data_rd), .irq(irq), .port_sel(port_sel),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .od_port_a(od_port_a), .od_port_b(od_port_b));

  always_comb begin
    if (lowpos == 8) slv_drv = ack_en && !slv_tx;
    else if (lowpos < 8) slv_drv = slv_tx && !sbyte[7 - lowpos];
    else slv_drv = 1'b0;
  end

  always @(posedge scl_bus) begin
    if (pcount < 8) srx = {srx[6:0], sda_bus};
    if (pcount == 8) mack = !sda_bus;
    pcount++;
  end
  always @(negedge scl_bus) begin
    if (pcount >= 9) pcount = 0;
    lowpos = pcount;
  end
  always @(negedge sda_bus) if (scl_bus === 1'b1) begin pcount = 0; starts++; end
  always @(posedge sda_bus) if (scl_bus === 1'b1) stops++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, "interrupt timeout", int'(irq), 1);
  endtask

  task automatic do_stop(input string req);
    int s0 = stops;
    ctl_write(8'h41);
    chk(irq == 1'b0, "R4", "irq after write", int'(irq), 0);
    wait_irq(req);
    chk(ctl_rd[1] == 1'b1 && ctl_rd[6] == 1'b0, req, "stop status", int'(ctl_rd), 8'h03);
    chk(stops == s0 + 1, req, "stop count", stops, s0 + 1);
  endtask

  localparam logic [8:0] VEC [4] = '{ {1'b1, 8'hA4}, {1'b0, 8'h3B}, {1'b1, 8'hFF}, {1'b0, 8'h00} };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0, t_base, t_str, s0, st0;
    bit drove;
    repeat (4) @(negedge clk);
    // R1
    chk(ctl_rd == 8'h00 && data_rd == 8'h00, "R1", "reset regs", int'({ctl_rd, data_rd}), 0);
    chk(!irq && !scl_oe && !sda_oe, "R1", "reset outputs", int'({irq, scl_oe, sda_oe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ctl_write(8'h01);
    // R11
    chk(od_port_a == 2'b11 && od_port_b == 2'b00, "R11", "port A open-drain", int'({od_port_a, od_port_b}), 4'hC);
    port_sel = 1'b1; @(negedge clk);
    chk(od_port_a == 2'b00 && od_port_b == 2'b11, "R11", "port B open-drain", int'({od_port_a, od_port_b}), 4'h3);
    port_sel = 1'b0;

    t_base = 0;
    foreach (VEC[i]) begin
      ack_en = VEC[i][8];
      data_write(VEC[i][7:0]);
      s0 = starts;
      t0 = cyc;
      ctl_write(8'hE1);
      wait_irq("R2");
      if (i == 0) t_base = cyc - t0;
      // R2 R5
      chk(starts == s0 + 1, "R2", "start seen", starts, s0 + 1);
      chk(srx == VEC[i][7:0], "R2", "address byte", int'(srx), int'(VEC[i][7:0]));
      chk(ctl_rd[4] == VEC[i][8], "R5", "ack status", int'(ctl_rd[4]), int'(VEC[i][8]));
      do_stop("R9");
    end

    // R3 busy interlock
    ack_en = 1'b1;
    data_write(8'h5A);
    ctl_write(8'hE1);
    chk(ctl_rd[6] == 1'b1, "R3", "busy after continue", int'(ctl_rd[6]), 1);
    ctl_write(8'h00);
    chk((ctl_rd & 8'hA1) == 8'hA1, "R3", "write while busy ignored", int'(ctl_rd & 8'hA1), 8'hA1);
    wait_irq("R3");
    chk(ctl_rd[6] == 1'b0, "R4", "busy clear at irq", int'(ctl_rd[6]), 0);
    chk(srx == 8'h5A, "R3", "byte intact", int'(srx), 8'h5A);

    // R6 receive with ACK then NACK
    slv_tx = 1'b1; sbyte = 8'h96;
    ctl_write(8'hD1);
    wait_irq("R6");
    chk(data_rd == 8'h96, "R6", "read byte 1", int'(data_rd), 8'h96);
    chk(mack == 1'b1, "R6", "master ACK", int'(mack), 1);
    sbyte = 8'h3C;
    ctl_write(8'hC1);
    wait_irq("R6");
    chk(data_rd == 8'h3C, "R6", "read byte 2", int'(data_rd), 8'h3C);
    chk(mack == 1'b0, "R6", "master NACK", int'(mack), 0);
    slv_tx = 1'b0;

    // R8 repeated start
    data_write(8'h51);
    s0 = starts; st0 = stops;
    ctl_write(8'hE5);
    wait_irq("R8");
    chk(starts == s0 + 1 && stops == st0, "R8", "restart without stop", starts - s0, 1);
    chk(srx == 8'h51, "R8", "byte after restart", int'(srx), 8'h51);
    chk(ctl_rd[2] == 1'b0, "R8", "restart bit cleared", int'(ctl_rd[2]), 0);
    do_stop("R9");

    // R10 clock stretching
    data_write(8'h3C);
    t0 = cyc;
    ctl_write(8'hE1);
    @(negedge scl_bus);
    stretch = 1'b1;
    repeat (100) @(negedge clk);
    stretch = 1'b0;
    wait_irq("R10");
    t_str = cyc - t0;
    chk(t_str > t_base + 80 && t_str < t_base + 200, "R10", "stretched byte time", t_str, t_base + 100);
    chk(srx == 8'h3C, "R10", "byte after stretch", int'(srx), 8'h3C);
    do_stop("R9");

    // R7 arbitration loss
    force_low = 1'b1;
    data_write(8'hA0);
    ctl_write(8'hE1);
    wait_irq("R7");
    repeat (3) @(negedge clk);
    chk(ctl_rd[7] == 1'b0 && ctl_rd[2] == 1'b1, "R7", "arb status", int'(ctl_rd), 8'h25);
    chk(!scl_oe && !sda_oe, "R7", "lines released", int'({scl_oe, sda_oe}), 0);
    force_low = 1'b0;
    ctl_write(8'h01);
    chk(irq == 1'b0, "R4", "irq cleared", int'(irq), 0);

    // R11 disabled engine never drives
    ack_en = 1'b0;
    ctl_write(8'h00);
    chk(od_port_a == 2'b00 && od_port_b == 2'b00, "R11", "no open-drain when off", int'({od_port_a, od_port_b}), 0);
    s0 = starts;
    drove = 1'b0;
    ctl_write(8'hE0);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (scl_oe || sda_oe) drove = 1'b1;
    end
    wait_irq("R11");
    chk(!drove && starts == s0, "R11", "lines untouched when off", int'(drove), 0);
    ctl_write(8'h40);
    wait_irq("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule